// File: doc/BRIEF.md
# Strobed Single-Bit Static RAM Bank

This block is a clocked model of a fully decoded static memory that stores one bit per word. Each core holds 64 words and is reached through a 6-bit word address, a data input bit, a read/write select and three select inputs: a strobe and two enables. A core is active only while all three select inputs are high in the same cycle. The three-state output is modelled as a data bit plus an output-enable flag.

Analog access timing is replaced by a fixed number of clock cycles of access latency. During that wait the output is already enabled and reads as 0. After the wait the stored bit appears with the polarity it was written with.

The top level joins several cores into one wider array. The upper address bits are decoded and ANDed into each core's strobe, so only one core is active at a time. The cores' outputs are merged onto a single shared data/enable pair. With the default parameters this gives 256 words of one bit.

Top module: `strobed_bit_ram_bank`

## Requirements
- R1: In the cycle after reset is applied, `dout_en` is 0 and `dout` is 0.
- R2: A clock edge with `strobe`, `en_a` and `en_b` all 1 and `rd_sel` = 0 stores `din` at `addr`. In the following cycle `dout_en` is 0.
- R3: If any of `strobe`, `en_a` or `en_b` is 0 at an edge, nothing is written and `dout_en` is 0 in the next cycle.
- R4: At the first edge of a selected read (`rd_sel` = 1), `dout_en` goes to 1 and `dout` is 0. `dout` stays 0 for ACCESS_CYCLES cycles and then shows the stored bit. `dout_en` stays 1 for as long as the read continues.
- R5: A read returns the stored bit with the same polarity it was written with: a written 1 reads 1 and a written 0 reads 0.
- R6: If `addr` changes while a read stays selected, `dout` returns to 0 and the latency wait restarts from its first cycle for the new address.
- R7: If `rd_sel` falls to 0 while selected, `dout_en` is 0 in the next cycle.
- R8: `addr[7:6]` picks one of four cores and `addr[5:0]` picks the word inside it. All 256 locations hold independent values.
- R9: No more than one core enables its output in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output/latency state (storage is not reset) |
| addr | input | 8 | Word address; the upper bits choose the core |
| din | input | 1 | Write data |
| rd_sel | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | Access strobe |
| en_a | input | 1 | First enable |
| en_b | input | 1 | Second enable |
| dout | output | 1 | Read data; 0 during the latency wait or when disabled |
| dout_en | output | 1 | Stands for the three-state driver being on |

## Verification
The assertions assume that the address, `rd_sel` and the select inputs are stable and known across each clock edge. They also assume that reset is applied before the first access. The stimulus meets these conditions by changing every input just after a rising edge and by holding reset for several cycles at the start. Storage is never reset, so the stimulus writes every location before any read that it checks.

// File: rtl/sram_bit_pkg.sv
package sram_bit_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_mode_e;

    localparam int DEF_WORD_ADDR_W = 6;
    localparam int DEF_ACCESS_CYC  = 2;
    localparam int DEF_BANKS       = 4;

    function automatic acc_mode_e decode_mode(input logic sel, input logic rd);
        if (!sel)    return ACC_IDLE;
        else if (rd) return ACC_READ;
        else         return ACC_WRITE;
    endfunction

endpackage

// File: rtl/bit_ram_core.sv
module bit_ram_core
    import sram_bit_pkg::*;
#(
    parameter int ADDR_W        = DEF_WORD_ADDR_W,
    parameter int ACCESS_CYCLES = DEF_ACCESS_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              oe
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int CW    = (ACCESS_CYCLES < 1) ? 1 : $clog2(ACCESS_CYCLES + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(ACCESS_CYCLES);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [CW-1:0]     cnt;
    } rd_state_t;

    logic [WORDS-1:0] mem;
    rd_state_t        st_q, st_d;
    acc_mode_e        mode;

    assign mode = decode_mode(sel, rd);

    always_ff @(posedge clk) begin
        if (mode == ACC_WRITE) mem[addr] <= din;
    end

    always_comb begin
        st_d = st_q;
        if (mode == ACC_READ) begin
            if (!st_q.active || st_q.addr != addr) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_DONE) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.active = 1'b1;
            st_d.addr   = addr;
        end else begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign oe   = st_q.active;
    assign dout = st_q.active && (st_q.cnt == CNT_DONE) && mem[st_q.addr];

    // R2, R3, R7: any non-read edge leaves the driver off
    p_off_unless_read_r7: assert property (@(posedge clk) disable iff (rst)
        (mode != ACC_READ) |=> !oe);

    // R4: entering a read drives the output low before valid data
    p_low_first_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == ACC_READ && !oe && ACCESS_CYCLES > 0) |=> (oe && !dout));

    // R6: a new address during a read restarts the wait
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == ACC_READ && oe && addr != st_q.addr && ACCESS_CYCLES > 0) |=> !dout);

endmodule

// File: rtl/strobed_bit_ram_bank.sv
module strobed_bit_ram_bank
    import sram_bit_pkg::*;
#(
    parameter int WORD_ADDR_W   = DEF_WORD_ADDR_W,
    parameter int BANKS         = DEF_BANKS,
    parameter int ACCESS_CYCLES = DEF_ACCESS_CYC
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [WORD_ADDR_W+$clog2(BANKS)-1:0]     addr,
    input  logic                                     din,
    input  logic                                     rd_sel,
    input  logic                                     strobe,
    input  logic                                     en_a,
    input  logic                                     en_b,
    output logic                                     dout,
    output logic                                     dout_en
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ADDR_W = WORD_ADDR_W + BANK_W;

    logic [BANKS-1:0] bank_sel, bank_dout, bank_oe;
    logic             chip_on;

    assign chip_on = strobe & en_a & en_b;

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            if (BANKS == 1) begin : g_single
                assign bank_sel[b] = chip_on;
            end else begin : g_multi
                assign bank_sel[b] = chip_on && (addr[ADDR_W-1:WORD_ADDR_W] == BANK_W'(b));
            end
            bit_ram_core #(
                .ADDR_W        (WORD_ADDR_W),
                .ACCESS_CYCLES (ACCESS_CYCLES)
            ) u_core (
                .clk  (clk),
                .rst  (rst),
                .sel  (bank_sel[b]),
                .rd   (rd_sel),
                .addr (addr[WORD_ADDR_W-1:0]),
                .din  (din),
                .dout (bank_dout[b]),
                .oe   (bank_oe[b])
            );
        end
    endgenerate

    assign dout    = |(bank_dout & bank_oe);
    assign dout_en = |bank_oe;

    // R9: shared output is driven by at most one core
    p_one_driver_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_oe));

    // R1: reset turns the output off
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (!dout_en && !dout));

endmodule

// File: tb/strobed_bit_ram_bank_bench.sv
module strobed_bit_ram_bank_bench;
    localparam int LAT = 2;

    logic       clk = 0, rst = 1;
    logic [7:0] addr = '0;
    logic       din = 0, rd_sel = 0, strobe = 0, en_a = 0, en_b = 0;
    logic       dout, dout_en;
    int         checks = 0, errors = 0;
    bit         done = 0;

    strobed_bit_ram_bank #(.ACCESS_CYCLES(LAT)) u_strobed_bit_ram_bank (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .rd_sel(rd_sel),
        .strobe(strobe), .en_a(en_a), .en_b(en_b), .dout(dout), .dout_en(dout_en)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b addr=%0d t=%0t", req, act, exp, addr, $time);
        end
    endtask

    function automatic logic pat(logic [7:0] a, logic inv);
        return a[0] ^ a[3] ^ a[7] ^ inv;
    endfunction

    task automatic write_word(logic [7:0] a, logic d);
        addr = a; din = d; rd_sel = 0; strobe = 1; en_a = 1; en_b = 1;
        step();
        check("R2 output off after write", dout_en, 1'b0);
        strobe = 0;
    endtask

    task automatic read_word(logic [7:0] a, logic exp, string req);
        addr = a; rd_sel = 1; strobe = 1; en_a = 1; en_b = 1;
        for (int i = 0; i <= LAT; i++) begin
            step();
            check("R4 enable during read", dout_en, 1'b1);
            check(req, dout, (i < LAT) ? 1'b0 : exp);
        end
        strobe = 0;
        step();
        check("R3 off when deselected", dout_en, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1; repeat (3) step();
        check("R1 enable after reset", dout_en, 1'b0);
        check("R1 data after reset", dout, 1'b0);
        rst = 0; step();
    endtask

    task automatic t_fill(logic inv);
        for (int a = 0; a < 256; a++) write_word(8'(a), pat(8'(a), inv));
    endtask

    task automatic t_read_all(logic inv);
        for (int a = 0; a < 256; a++) read_word(8'(a), pat(8'(a), inv), "R8 R5 stored value");
    endtask

    task automatic t_blocked_writes();
        // each select input low in turn: write of inverted data must not land (R3)
        for (int k = 0; k < 3; k++) begin
            addr = 8'd77; din = ~pat(8'd77, 0); rd_sel = 0;
            strobe = (k != 0); en_a = (k != 1); en_b = (k != 2);
            step();
            check("R3 off when not selected", dout_en, 1'b0);
            rd_sel = 1;
            step();
            check("R3 no read when not selected", dout_en, 1'b0);
            strobe = 0; en_a = 0; en_b = 0;
            read_word(8'd77, pat(8'd77, 0), "R3 blocked write ignored");
        end
    endtask

    task automatic t_polarity();
        write_word(8'd200, 1'b1); read_word(8'd200, 1'b1, "R5 one reads one");
        write_word(8'd200, 1'b0); read_word(8'd200, 1'b0, "R5 zero reads zero");
        write_word(8'd200, pat(8'd200, 0));
    endtask

    task automatic t_addr_restart();
        write_word(8'd5, 1'b1); write_word(8'd6, 1'b1);
        addr = 8'd5; rd_sel = 1; strobe = 1; en_a = 1; en_b = 1;
        repeat (LAT + 1) step();
        check("R6 first address valid", dout, 1'b1);
        addr = 8'd6;
        for (int i = 0; i <= LAT; i++) begin
            step();
            check("R6 enable kept", dout_en, 1'b1);
            check("R6 restarted wait", dout, (i < LAT) ? 1'b0 : 1'b1);
        end
        addr = 8'd133; // other core, same low bits region change
        step();
        check("R9 single driver after core switch", dout_en, 1'b1);
        check("R6 restart across cores", dout, 1'b0);
        strobe = 0; step();
        write_word(8'd5, pat(8'd5, 0)); write_word(8'd6, pat(8'd6, 0));
    endtask

    task automatic t_rd_drop();
        addr = 8'd9; rd_sel = 1; strobe = 1; en_a = 1; en_b = 1;
        repeat (LAT + 1) step();
        check("R4 data after wait", dout, pat(8'd9, 0));
        rd_sel = 0; din = pat(8'd9, 0);
        step();
        check("R7 off after rd_sel falls", dout_en, 1'b0);
        check("R7 data zero", dout, 1'b0);
        strobe = 0; step();
    endtask

    initial begin
        t_reset();
        t_fill(1'b0);
        t_read_all(1'b0);
        t_blocked_writes();
        t_polarity();
        t_addr_restart();
        t_rd_drop();
        t_fill(1'b1);
        t_read_all(1'b1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=running expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule